// File: doc/BRIEF.md
# Frame-Synchronized Full-Duplex Serial Port

This block is a synchronous serial port for a signal-processing core. It has a receiver and a transmitter, and each side moves 16-bit words most significant bit first. A falling edge on a frame-sync line starts every word. The receiver then samples serial data on the falling edges of its bit clock. The transmitter changes its data line on the rising edges of its bit clock. The core reaches the port through two strobes: `wr_en` loads a word to transmit and `rd_en` takes a received word. Flags report a full receive buffer, an overrun and an empty transmit buffer.

Two mode inputs choose where the transmit bit clock and the transmit frame sync come from. When the port generates the bit clock itself, the clock runs at one quarter of the system clock. When the port generates the frame sync, a write to an idle transmitter causes a single-cycle frame-sync pulse. All pin inputs pass through two-stage synchronizers, and every edge is detected in the system clock domain. The port does not drive pads directly. It drives an output-enable beside each output it may drive, and an active-low off input forces all of these enables inactive. While a side is idle, the level on its clock pin can be read back as a plain input.

Top module: `fsync_serial_port`

## Requirements
- R1: After a falling edge on `rfs_in`, the next 16 falling edges of `rclk_in` each capture one `rdata_in` bit, MSB first. After the 16th bit the word appears on `rd_data` and `rx_full` goes to 1.
- R2: A pulse on `rd_en` clears both `rx_full` and `rx_overrun`. If a word completes while `rx_full` is 1 and no read occurs in that cycle, the new word replaces the one on `rd_data` and `rx_overrun` goes to 1.
- R3: Once a transmit has started, each rising edge of the transmit bit clock puts the next word bit on `xdata_out`, MSB first. `xdata_oe` goes to 1 with the first bit and returns to 0 on the 17th rising edge.
- R4: With `ctl_clk_gen`=1, `xclk_out` is a square wave with a period of 4 system clocks, `xclk_oe`=1, and this clock paces transmission. With `ctl_clk_gen`=0, `xclk_oe`=0 and the rising edges of `xclk_in` pace transmission.
- R5: With `ctl_fs_gen`=0, `xfs_oe`=0 and a falling edge of `xfs_in` starts a transmit. With `ctl_fs_gen`=1, `xfs_oe`=1. A write while the transmitter is idle then drives `xfs_out` high for exactly one system cycle, and the falling edge of that pulse starts the transmit.
- R6: A write clears `tx_empty`. When a transmitted word completes, `tx_empty` goes to 1.
- R7: While the receiver is idle, `rclk_level` follows the level on `rclk_in` within 4 system cycles. While the transmitter is idle, `xclk_level` does the same for `xclk_in`.
- R8: While `off_n`=0, `xclk_oe`, `xfs_oe` and `xdata_oe` are all 0, whatever the modes are and whatever the transmitter is doing.
- R9: After reset with both mode inputs at 0, the outputs are: `rx_full`=0, `rx_overrun`=0, `tx_empty`=1, and all three output-enables 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_clk_gen | input | 1 | 1: the port generates the transmit bit clock |
| ctl_fs_gen | input | 1 | 1: the port generates the transmit frame sync |
| off_n | input | 1 | Active-low global output disable |
| rclk_in | input | 1 | Receive bit clock |
| rfs_in | input | 1 | Receive frame sync; a falling edge starts a word |
| rdata_in | input | 1 | Receive serial data |
| rd_en | input | 1 | Read strobe for the receive buffer |
| rd_data | output | 16 | Receive buffer contents |
| rx_full | output | 1 | An unread word is in the receive buffer |
| rx_overrun | output | 1 | A word was overwritten before it was read |
| rclk_level | output | 1 | Sampled level of `rclk_in` while the receiver is idle |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | 16 | Word to transmit |
| tx_empty | output | 1 | The transmit buffer has been sent |
| xclk_in | input | 1 | External transmit bit clock |
| xclk_out | output | 1 | Generated transmit bit clock |
| xclk_oe | output | 1 | Output enable for `xclk_out` |
| xfs_in | input | 1 | External transmit frame sync |
| xfs_out | output | 1 | Generated transmit frame-sync pulse |
| xfs_oe | output | 1 | Output enable for `xfs_out` |
| xdata_out | output | 1 | Transmit serial data |
| xdata_oe | output | 1 | Output enable for `xdata_out` |
| xclk_level | output | 1 | Sampled level of `xclk_in` while the transmitter is idle |

## Verification
The bench sends words with a single bit set at each end, and words that are all ones or all zeros. These patterns catch a design that sends or captures LSB first, or that is off by one bit position. It lets two words arrive without a read between them: a design with a broken overrun rule would keep the stale word or leave the flag low. It runs the transmitter both from pin-supplied clock and frame sync and from generated ones. A design that mixes up the mode selects would never start, or would drive `xdata_oe` on the wrong clock. It also holds `off_n` low during a generated transmission and checks the width of the frame-sync pulse. The idle clock-pin read-back is toggled with both sides quiet.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  // Synchronized view of one pin: current level plus single-cycle edge strobes.
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } pin_ev_t;
endpackage

// File: rtl/fsp_pin_sync.sv
module fsp_pin_sync
  import fsp_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pin,
  output pin_ev_t ev
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin};
      last_q  <= chain_q[STAGES-1];
    end
  end

  always_comb begin
    ev.level = chain_q[STAGES-1];
    ev.rise  = chain_q[STAGES-1] & ~last_q;
    ev.fall  = ~chain_q[STAGES-1] & last_q;
  end
endmodule

// File: rtl/fsp_rx.sv
module fsp_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_fall,
  input  logic              bclk_fall,
  input  logic              bclk_level,
  input  logic              dat_level,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              full,
  output logic              overrun,
  output logic              idle_level
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic              active_q, active_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d, buf_q, buf_d;
  logic              full_q, full_d, ovr_q, ovr_d, lvl_q, lvl_d;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    buf_d    = buf_q;
    full_d   = full_q;
    ovr_d    = ovr_q;
    lvl_d    = active_q ? lvl_q : bclk_level;
    if (rd_en) begin
      full_d = 1'b0;
      ovr_d  = 1'b0;
    end
    if (fs_fall) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (active_q && bclk_fall) begin
      sh_d = {sh_q[WORD_W-2:0], dat_level};
      if (cnt_q == LAST_BIT) begin
        active_d = 1'b0;
        cnt_d    = '0;
        buf_d    = sh_d;
        full_d   = 1'b1;
        if (full_q && !rd_en) ovr_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      buf_q    <= '0;
      full_q   <= 1'b0;
      ovr_q    <= 1'b0;
      lvl_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      buf_q    <= buf_d;
      full_q   <= full_d;
      ovr_q    <= ovr_d;
      lvl_q    <= lvl_d;
    end
  end

  assign rd_data    = buf_q;
  assign full       = full_q;
  assign overrun    = ovr_q;
  assign idle_level = lvl_q;

  // R2: an overrun is only ever recorded on top of an unread word
  p_overrun_implies_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> full_q);
  // R2: a read always empties the buffer on the next cycle unless a word lands
  p_read_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !(active_q && bclk_fall && cnt_q == LAST_BIT)) |=> !full_q);
  // R1: a word completes and the receiver goes idle only after its last bit
  p_word_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !active_d && !fs_fall) |-> (cnt_q == LAST_BIT));
endmodule

// File: rtl/fsp_tx.sv
module fsp_tx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_gen,
  input  logic              ext_fs_fall,
  input  logic              tclk_rise,
  input  logic              pin_clk_level,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              dout,
  output logic              drive,
  output logic              empty,
  output logic              fs_pulse,
  output logic              idle_level
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(WORD_W);

  logic [WORD_W-1:0] buf_q, buf_d, sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic busy_q, busy_d, drive_q, drive_d, dout_q, dout_d;
  logic empty_q, empty_d, fs_q, fs_d, lvl_q, lvl_d;
  logic start;

  always_comb begin
    start   = fs_gen ? fs_q : ext_fs_fall;
    fs_d    = fs_gen & wr_en & ~busy_q & ~fs_q;
    buf_d   = buf_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    drive_d = drive_q;
    dout_d  = dout_q;
    empty_d = empty_q;
    lvl_d   = busy_q ? lvl_q : pin_clk_level;
    if (wr_en) begin
      buf_d   = wr_data;
      empty_d = 1'b0;
    end
    if (start) begin
      sh_d    = buf_q;
      busy_d  = 1'b1;
      cnt_d   = '0;
      drive_d = 1'b0;
    end else if (busy_q && tclk_rise) begin
      if (cnt_q == END_CNT) begin
        busy_d  = 1'b0;
        drive_d = 1'b0;
        if (!wr_en) empty_d = 1'b1;
      end else begin
        dout_d  = sh_q[WORD_W-1];
        sh_d    = {sh_q[WORD_W-2:0], 1'b0};
        drive_d = 1'b1;
        cnt_d   = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      sh_q    <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      drive_q <= 1'b0;
      dout_q  <= 1'b0;
      empty_q <= 1'b1;
      fs_q    <= 1'b0;
      lvl_q   <= 1'b0;
    end else begin
      buf_q   <= buf_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
      drive_q <= drive_d;
      dout_q  <= dout_d;
      empty_q <= empty_d;
      fs_q    <= fs_d;
      lvl_q   <= lvl_d;
    end
  end

  assign dout       = dout_q;
  assign drive      = drive_q;
  assign empty      = empty_q;
  assign fs_pulse   = fs_q;
  assign idle_level = lvl_q;

  // R3: the data line is only enabled inside an active word
  p_drive_in_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drive_q |-> busy_q);
  // R5: a generated frame sync lasts exactly one system cycle
  p_fs_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |=> !fs_q);
  // R6: a write always leaves the buffer marked non-empty
  p_write_clears_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !empty_q);
endmodule

// File: rtl/fsync_serial_port.sv
module fsync_serial_port
  import fsp_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LOG2    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_clk_gen,
  input  logic              ctl_fs_gen,
  input  logic              off_n,
  input  logic              rclk_in,
  input  logic              rfs_in,
  input  logic              rdata_in,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rx_full,
  output logic              rx_overrun,
  output logic              rclk_level,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              tx_empty,
  input  logic              xclk_in,
  output logic              xclk_out,
  output logic              xclk_oe,
  input  logic              xfs_in,
  output logic              xfs_out,
  output logic              xfs_oe,
  output logic              xdata_out,
  output logic              xdata_oe,
  output logic              xclk_level
);
  localparam int NPIN     = 5;
  localparam int P_RCLK   = 0;
  localparam int P_RFS    = 1;
  localparam int P_RDATA  = 2;
  localparam int P_XCLK   = 3;
  localparam int P_XFS    = 4;
  localparam int DIV_MSB  = DIV_LOG2 - 1;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // Pin synchronizers
  logic [NPIN-1:0] pins;
  pin_ev_t         ev [NPIN];
  assign pins = {xfs_in, xclk_in, rdata_in, rfs_in, rclk_in};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    fsp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_core_n),
      .pin  (pins[g]),
      .ev   (ev[g])
    );
  end

  logic unused_ev_bits;
  assign unused_ev_bits = ^{ev[P_RCLK].rise, ev[P_RFS].rise, ev[P_RFS].level,
                            ev[P_RDATA].rise, ev[P_RDATA].fall, ev[P_XCLK].fall,
                            ev[P_XFS].rise, ev[P_XFS].level};

  // Transmit bit-clock generator: divide by 2**DIV_LOG2
  logic [DIV_LOG2-1:0] div_q, div_d;
  logic                gen_last_q, gen_rise, tclk_rise;

  always_comb div_d = ctl_clk_gen ? div_q + 1'b1 : '0;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      div_q      <= '0;
      gen_last_q <= 1'b0;
    end else begin
      div_q      <= div_d;
      gen_last_q <= div_q[DIV_MSB];
    end
  end

  assign gen_rise  = div_q[DIV_MSB] & ~gen_last_q;
  assign tclk_rise = ctl_clk_gen ? gen_rise : ev[P_XCLK].rise;

  fsp_rx #(.WORD_W(WORD_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .fs_fall   (ev[P_RFS].fall),
    .bclk_fall (ev[P_RCLK].fall),
    .bclk_level(ev[P_RCLK].level),
    .dat_level (ev[P_RDATA].level),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .full      (rx_full),
    .overrun   (rx_overrun),
    .idle_level(rclk_level)
  );

  logic tx_dout, tx_drive, tx_fs;

  fsp_tx #(.WORD_W(WORD_W)) u_tx (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .fs_gen       (ctl_fs_gen),
    .ext_fs_fall  (ev[P_XFS].fall),
    .tclk_rise    (tclk_rise),
    .pin_clk_level(ev[P_XCLK].level),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .dout         (tx_dout),
    .drive        (tx_drive),
    .empty        (tx_empty),
    .fs_pulse     (tx_fs),
    .idle_level   (xclk_level)
  );

  assign xclk_out  = div_q[DIV_MSB];
  assign xfs_out   = tx_fs;
  assign xdata_out = tx_dout;
  assign xclk_oe   = ctl_clk_gen & off_n;
  assign xfs_oe    = ctl_fs_gen & off_n;
  assign xdata_oe  = tx_drive & off_n;

  // R4: successive generated rising edges are never adjacent
  p_gen_rise_spacing_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    gen_rise |=> !gen_rise);
endmodule

// File: tb/fsync_serial_port_tb.sv
module fsync_serial_port_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ctl_clk_gen, ctl_fs_gen, off_n;
  logic rclk_in, rfs_in, rdata_in, rd_en, wr_en;
  logic [15:0] wr_data, rd_data;
  logic rx_full, rx_overrun, rclk_level, tx_empty;
  logic xclk_in, xclk_out, xclk_oe, xfs_in, xfs_out, xfs_oe;
  logic xdata_out, xdata_oe, xclk_level;

  fsync_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_clk_gen(ctl_clk_gen), .ctl_fs_gen(ctl_fs_gen),
    .off_n(off_n), .rclk_in(rclk_in), .rfs_in(rfs_in), .rdata_in(rdata_in),
    .rd_en(rd_en), .rd_data(rd_data), .rx_full(rx_full), .rx_overrun(rx_overrun),
    .rclk_level(rclk_level), .wr_en(wr_en), .wr_data(wr_data), .tx_empty(tx_empty),
    .xclk_in(xclk_in), .xclk_out(xclk_out), .xclk_oe(xclk_oe), .xfs_in(xfs_in),
    .xfs_out(xfs_out), .xfs_oe(xfs_oe), .xdata_out(xdata_out), .xdata_oe(xdata_oe),
    .xclk_level(xclk_level)
  );

  // {receive word, transmit word}
  localparam logic [31:0] VEC [6] = '{
    {16'h0000, 16'hFFFF}, {16'hFFFF, 16'h0000}, {16'h8001, 16'h7FFE},
    {16'hA5A5, 16'h5A5A}, {16'h1234, 16'hFEDC}, {16'h0001, 16'h8000}
  };

  int n_vec = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rx_word(input logic [15:0] w);
    rclk_in = 1'b1; rfs_in = 1'b1; cyc(4);
    rfs_in = 1'b0; cyc(6);
    for (int i = 15; i >= 0; i--) begin
      rdata_in = w[i]; rclk_in = 1'b1; cyc(3);
      rclk_in = 1'b0; cyc(3);
    end
    rclk_in = 1'b1; rfs_in = 1'b1; cyc(6);
  endtask

  task automatic do_read();
    rd_en = 1'b1; cyc(1); rd_en = 1'b0; cyc(1);
  endtask

  task automatic do_write(input logic [15:0] w);
    wr_data = w; wr_en = 1'b1; cyc(1); wr_en = 1'b0;
  endtask

  task automatic tx_collect(output logic [15:0] w);
    w = '0;
    while (!xdata_oe) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      @(negedge xclk_out);
      #1 w = {w[14:0], xdata_out};
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    logic [15:0] got;
    time t0;
    rst_n = 1'b0; ctl_clk_gen = 1'b0; ctl_fs_gen = 1'b0; off_n = 1'b1;
    rclk_in = 1'b1; rfs_in = 1'b1; rdata_in = 1'b0; rd_en = 1'b0;
    wr_en = 1'b0; wr_data = '0; xclk_in = 1'b0; xfs_in = 1'b1;
    cyc(4); rst_n = 1'b1; cyc(8);

    // R9 reset state
    chk(rx_full == 1'b0, "R9 rx_full", rx_full, 0);
    chk(rx_overrun == 1'b0, "R9 rx_overrun", rx_overrun, 0);
    chk(tx_empty == 1'b1, "R9 tx_empty", tx_empty, 1);
    chk({xclk_oe, xfs_oe, xdata_oe} == 3'b000, "R9 oe", {xclk_oe, xfs_oe, xdata_oe}, 0);

    // Vector table: receive then generated-mode transmit
    ctl_clk_gen = 1'b1; ctl_fs_gen = 1'b1; cyc(4);
    chk(xclk_oe && xfs_oe, "R4/R5 gen oe", {xclk_oe, xfs_oe}, 2'b11);
    for (int v = 0; v < 6; v++) begin
      rx_word(VEC[v][31:16]);
      chk(rx_full == 1'b1, "R1 full", rx_full, 1);
      chk(rd_data == VEC[v][31:16], "R1 data", rd_data, VEC[v][31:16]);
      do_read();
      chk(rx_full == 1'b0, "R2 read clears", rx_full, 0);
      do_write(VEC[v][15:0]);
      chk(xfs_out == 1'b1, "R5 pulse high", xfs_out, 1);
      chk(tx_empty == 1'b0, "R6 write clears", tx_empty, 0);
      cyc(1);
      chk(xfs_out == 1'b0, "R5 pulse width", xfs_out, 0);
      tx_collect(got);
      chk(got == VEC[v][15:0], "R3 tx data", got, VEC[v][15:0]);
      cyc(8);
      chk(xdata_oe == 1'b0, "R3 oe after word", xdata_oe, 0);
      chk(tx_empty == 1'b1, "R6 set at end", tx_empty, 1);
    end

    // R4 generated clock period
    @(posedge xclk_out); t0 = $time;
    @(posedge xclk_out);
    chk(($time - t0) == 40, "R4 period", 32'($time - t0), 40);

    // R2 overrun
    rx_word(16'h1111);
    rx_word(16'h2222);
    chk(rx_overrun == 1'b1, "R2 overrun set", rx_overrun, 1);
    chk(rd_data == 16'h2222, "R2 overwrite", rd_data, 16'h2222);
    do_read();
    chk({rx_full, rx_overrun} == 2'b00, "R2 read clears both", {rx_full, rx_overrun}, 0);

    // R8 global off during a generated transmit
    off_n = 1'b0; cyc(1);
    chk({xclk_oe, xfs_oe} == 2'b00, "R8 clk/fs oe", {xclk_oe, xfs_oe}, 0);
    begin
      bit saw_oe = 1'b0;
      do_write(16'hC3C3);
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (xdata_oe) saw_oe = 1'b1;
      end
      chk(!saw_oe, "R8 data oe", saw_oe, 0);
    end
    off_n = 1'b1; cyc(1);
    chk({xclk_oe, xfs_oe} == 2'b11, "R8 release", {xclk_oe, xfs_oe}, 2'b11);

    // R7 idle clock-pin read-back
    rclk_in = 1'b0; cyc(4);
    chk(rclk_level == 1'b0, "R7 rclk low", rclk_level, 0);
    rclk_in = 1'b1; cyc(4);
    chk(rclk_level == 1'b1, "R7 rclk high", rclk_level, 1);

    // External clock and frame sync
    ctl_clk_gen = 1'b0; ctl_fs_gen = 1'b0; xclk_in = 1'b1; cyc(4);
    chk(xclk_level == 1'b1, "R7 xclk high", xclk_level, 1);
    xclk_in = 1'b0; cyc(4);
    chk(xclk_level == 1'b0, "R7 xclk low", xclk_level, 0);
    chk({xclk_oe, xfs_oe} == 2'b00, "R4/R5 ext oe", {xclk_oe, xfs_oe}, 0);
    do_write(16'hB00F); cyc(4);
    chk(xdata_oe == 1'b0, "R5 no start without fs", xdata_oe, 0);
    xfs_in = 1'b0; cyc(6);
    got = '0;
    for (int i = 0; i < 17; i++) begin
      xclk_in = 1'b1; cyc(5);
      if (i < 16) begin
        got = {got[14:0], xdata_out};
        chk(xdata_oe == 1'b1, "R3 ext oe", xdata_oe, 1);
      end
      xclk_in = 1'b0; cyc(6);
    end
    xfs_in = 1'b1;
    chk(got == 16'hB00F, "R4 ext clock data", got, 16'hB00F);
    chk(xdata_oe == 1'b0, "R3 ext end", xdata_oe, 0);
    chk(tx_empty == 1'b1, "R6 ext end", tx_empty, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule